// File: doc/BRIEF.md
# SPI Register Access Slave

This block lets an SPI host read and write a bank of 8-bit registers inside a serial-port peripheral. Each transaction is one 16-bit frame. The first byte is a command: its top bit picks write (1) or read (0), and the other seven bits give the address. The second byte carries the write data. On a read, the addressed value is shifted back during that second byte.

Address zero is special. It is not a storage location but a window onto the peripheral's queues. A completed read there produces a one-cycle pop strobe toward the receive queue and returns the queue's head byte. A completed write there produces a one-cycle push strobe with the data byte toward the transmit queue. The top address returns a fixed revision code. The addresses in between are plain configuration bytes, exported in parallel to the rest of the peripheral.

SCLK, chip select and MOSI are brought into the system clock through two-flop synchronizers, and all frame logic runs on the system clock. The SPI clock must therefore be much slower than the system clock.

Top module: `spi_reg_slave`

## Requirements
- R1: A frame is 16 bits, sent MSB first in SPI mode 0 (MOSI sampled on rising SCLK, MISO changed after falling SCLK). Bit 15 = 1 means write and 0 means read, bits 14:8 are the address, and bits 7:0 are the write data.
- R2: A completed write to an address from 1 to NUM_REGS-2 stores the data byte. Address a appears on `regs_o[(a-1)*8 +: 8]` and reads back through SPI. Register contents change only when a write frame commits.
- R3: On a read, MISO carries the addressed byte MSB first during bits 7:0 of the frame. The byte is taken when the 8th rising edge is seen.
- R4: Address NUM_REGS-1 (0x1F by default) always reads REV_ID (0xA1 by default), and writes to it have no effect.
- R5: A completed read of address 0 returns `rx_data` on MISO and raises `rx_pop` for exactly one system clock, four system clocks after the 16th rising SCLK edge is driven.
- R6: A completed write to address 0 raises `tx_push` for exactly one system clock, with `tx_data` equal to the data byte, at the same latency as R5. It changes no register.
- R7: If chip select rises before the 16th rising edge, the frame is discarded: no register changes and no strobe is issued.
- R8: `miso_oe` is high only while the synchronized chip select is low, which is two system clocks behind `cs_n`.
- R9: Addresses from NUM_REGS up to 127 read as zero, and writes to them have no effect.
- R10: After reset all stored registers are zero, both strobes are low and `miso_oe` is low.
- R11: Rising edges after the 16th within one chip-select period are ignored. A frame commits at most once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI clock from the host (idle low) |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | High while MISO should be driven |
| rx_data | input | 8 | Head byte of the receive queue |
| rx_pop | output | 1 | One-cycle pop request to the receive queue |
| tx_push | output | 1 | One-cycle push request to the transmit queue |
| tx_data | output | 8 | Byte to push into the transmit queue |
| regs_o | output | 240 | Stored registers 1..30, eight bits each |

## Verification
The bench targets the points where a careless frame engine goes wrong:
- A frame cut short after 12 or 15 edges must leave the registers and both strobes untouched. An engine that commits on chip-select rise, or on any partial count, would write garbage or pop a byte.
- A frame with 20 edges must commit exactly once, with the first 16 bits. An engine that keeps shifting would store the trailing ones.
- The revision address and unmapped addresses are written and then read back. This exposes a decoder that lets writes land there, or one that returns aliased data.
- Every clock, the register image and the strobes are compared with a behavioural model. An off-by-one latency or a two-cycle strobe is caught as soon as it appears.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

    typedef enum logic [1:0] {
        ACC_FIFO = 2'd0,
        ACC_REG  = 2'd1,
        ACC_REV  = 2'd2,
        ACC_NONE = 2'd3
    } acc_e;

    // Address class: 0 is the queue window, the top entry is the revision code.
    function automatic acc_e classify(input int unsigned addr, input int unsigned nregs);
        if (addr == 0)              return ACC_FIFO;
        else if (addr < nregs - 1)  return ACC_REG;
        else if (addr == nregs - 1) return ACC_REV;
        else                        return ACC_NONE;
    endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int unsigned     W       = 1,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [1:0][W-1:0] st_d, st_q;

    always_comb begin
        st_d = {st_q[0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= {RST_VAL, RST_VAL};
        else        st_q <= st_d;
    end

    assign dout = st_q[1];
endmodule

// File: rtl/spi_frame.sv
module spi_frame #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              cs_n_s,
    input  logic              mosi_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              done,
    output logic              done_wr,
    output logic [ADDR_W-1:0] done_addr,
    output logic [DATA_W-1:0] done_data,
    output logic              miso,
    output logic              miso_oe
);
    localparam int unsigned FRAME_W = 1 + ADDR_W + DATA_W;
    localparam int unsigned CMD_W   = 1 + ADDR_W;
    localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] LAST    = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CMD_END = CNT_W'(CMD_W);

    typedef struct packed {
        logic               sclk_prev;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] shift;
        logic [DATA_W-1:0]  out;
        logic               miso;
        logic               done;
    } state_t;

    state_t d, q;
    logic   rise, fall;

    assign rise    = sclk_s & ~q.sclk_prev;
    assign fall    = ~sclk_s & q.sclk_prev;
    // Address as it will stand once the current bit is shifted in.
    assign rd_addr = {q.shift[ADDR_W-2:0], mosi_s};

    always_comb begin
        d           = q;
        d.done      = 1'b0;
        d.sclk_prev = sclk_s;
        if (cs_n_s) begin
            d.cnt  = '0;
            d.miso = 1'b0;
        end else begin
            if (rise && (q.cnt < LAST)) begin
                d.shift = {q.shift[FRAME_W-2:0], mosi_s};
                d.cnt   = q.cnt + 1'b1;
                if (d.cnt == CMD_END) d.out  = rd_data;
                if (d.cnt == LAST)    d.done = 1'b1;
            end
            if (fall) begin
                if ((q.cnt >= CMD_END) && (q.cnt < LAST)) begin
                    d.miso = q.out[DATA_W-1];
                    d.out  = {q.out[DATA_W-2:0], 1'b0};
                end else begin
                    d.miso = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done      = q.done;
    assign done_wr   = q.shift[FRAME_W-1];
    assign done_addr = q.shift[FRAME_W-2 -: ADDR_W];
    assign done_data = q.shift[DATA_W-1:0];
    assign miso      = q.miso;
    assign miso_oe   = ~cs_n_s;
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
    import spi_reg_pkg::*;
#(
    parameter int unsigned       DATA_W   = 8,
    parameter int unsigned       ADDR_W   = 7,
    parameter int unsigned       NUM_REGS = 32,
    parameter logic [DATA_W-1:0] REV_ID   = 8'hA1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [ADDR_W-1:0]                  rd_addr,
    input  logic [DATA_W-1:0]                  rx_data,
    output logic [DATA_W-1:0]                  rd_data,
    input  logic                               commit,
    input  logic                               commit_wr,
    input  logic [ADDR_W-1:0]                  commit_addr,
    input  logic [DATA_W-1:0]                  commit_data,
    output logic [(NUM_REGS-2)*DATA_W-1:0]     regs_o,
    output logic                               rx_pop,
    output logic                               tx_push,
    output logic [DATA_W-1:0]                  tx_data
);
    localparam int unsigned NSTORE = NUM_REGS - 2;

    typedef struct packed {
        logic [NSTORE-1:0][DATA_W-1:0] regs;
        logic                          pop;
        logic                          push;
        logic [DATA_W-1:0]             txd;
    } state_t;

    state_t d, q;
    acc_e   rd_cls, wr_cls;

    assign rd_cls = classify(32'(rd_addr), NUM_REGS);
    assign wr_cls = classify(32'(commit_addr), NUM_REGS);

    always_comb begin
        rd_data = '0;
        case (rd_cls)
            ACC_FIFO: rd_data = rx_data;
            ACC_REV:  rd_data = REV_ID;
            ACC_REG: begin
                for (int i = 0; i < int'(NSTORE); i++) begin
                    if (rd_addr == ADDR_W'(i + 1)) rd_data = q.regs[i];
                end
            end
            default:  rd_data = '0;
        endcase
    end

    always_comb begin
        d      = q;
        d.pop  = 1'b0;
        d.push = 1'b0;
        if (commit) begin
            case (wr_cls)
                ACC_FIFO: begin
                    if (commit_wr) begin
                        d.push = 1'b1;
                        d.txd  = commit_data;
                    end else begin
                        d.pop  = 1'b1;
                    end
                end
                ACC_REG: begin
                    if (commit_wr) begin
                        for (int i = 0; i < int'(NSTORE); i++) begin
                            if (commit_addr == ADDR_W'(i + 1)) d.regs[i] = commit_data;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign regs_o  = q.regs;
    assign rx_pop  = q.pop;
    assign tx_push = q.push;
    assign tx_data = q.txd;
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave #(
    parameter int unsigned       DATA_W   = 8,
    parameter int unsigned       ADDR_W   = 7,
    parameter int unsigned       NUM_REGS = 32,
    parameter logic [DATA_W-1:0] REV_ID   = 8'hA1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           sclk,
    input  logic                           cs_n,
    input  logic                           mosi,
    output logic                           miso,
    output logic                           miso_oe,
    input  logic [DATA_W-1:0]              rx_data,
    output logic                           rx_pop,
    output logic                           tx_push,
    output logic [DATA_W-1:0]              tx_data,
    output logic [(NUM_REGS-2)*DATA_W-1:0] regs_o
);
    logic              sclk_s, cs_n_s, mosi_s;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              frm_done, frm_wr;
    logic [ADDR_W-1:0] frm_addr;
    logic [DATA_W-1:0] frm_data;

    spi_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sclk, cs_n, mosi}),
        .dout ({sclk_s, cs_n_s, mosi_s})
    );

    spi_frame #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (sclk_s),
        .cs_n_s   (cs_n_s),
        .mosi_s   (mosi_s),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .done     (frm_done),
        .done_wr  (frm_wr),
        .done_addr(frm_addr),
        .done_data(frm_data),
        .miso     (miso),
        .miso_oe  (miso_oe)
    );

    spi_reg_bank #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .REV_ID(REV_ID)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_addr    (rd_addr),
        .rx_data    (rx_data),
        .rd_data    (rd_data),
        .commit     (frm_done),
        .commit_wr  (frm_wr),
        .commit_addr(frm_addr),
        .commit_data(frm_data),
        .regs_o     (regs_o),
        .rx_pop     (rx_pop),
        .tx_push    (tx_push),
        .tx_data    (tx_data)
    );
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned ADDR_W   = 7,
    parameter int unsigned NUM_REGS = 32
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           cs_n,
    input logic                           miso_oe,
    input logic                           rx_pop,
    input logic                           tx_push,
    input logic [(NUM_REGS-2)*DATA_W-1:0] regs_o,
    input logic                           done,
    input logic                           done_wr,
    input logic [ADDR_W-1:0]              done_addr
);
    p_pop_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |=> !rx_pop);

    p_push_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |=> !tx_push);

    p_pop_after_read0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> $past(done && !done_wr && (done_addr == '0)));

    p_push_after_write0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |-> $past(done && done_wr && (done_addr == '0)));

    p_regs_only_on_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs_o) |-> $past(done && done_wr));

    p_oe_off_deselected_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n, 2) |-> !miso_oe);

    p_no_pop_and_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_pop && tx_push));
endmodule

bind spi_reg_slave spi_reg_slave_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .miso_oe  (miso_oe),
    .rx_pop   (rx_pop),
    .tx_push  (tx_push),
    .regs_o   (regs_o),
    .done     (frm_done),
    .done_wr  (frm_wr),
    .done_addr(frm_addr)
);

// File: tb/test_spi_reg_slave.sv
module test_spi_reg_slave;
    localparam int HALF = 8;
    localparam int NST  = 30;

    logic         clk = 1'b0, rst_n = 1'b0;
    logic         sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic         miso, miso_oe, rx_pop, tx_push;
    logic [7:0]   rx_data = 8'h00, tx_data;
    logic [239:0] regs_o;

    spi_reg_slave i_spi_reg_slave (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe), .rx_data(rx_data), .rx_pop(rx_pop),
        .tx_push(tx_push), .tx_data(tx_data), .regs_o(regs_o)
    );

    always #5 clk = ~clk;

    int          n_chk = 0, n_bad = 0;
    logic [7:0]  mregs [1:NST];
    int          pend = 0;
    logic [15:0] pend_word = '0;
    logic        exp_pop = 1'b0, exp_push = 1'b0;
    logic [7:0]  exp_txd = '0;

    task automatic check(input bit ok, input string tag, input logic [239:0] act, input logic [239:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [239:0] model_flat();
        logic [239:0] f;
        for (int i = 1; i <= NST; i++) f[(i-1)*8 +: 8] = mregs[i];
        return f;
    endfunction

    function automatic logic [7:0] mread(input logic [6:0] a);
        if (a == 0) return rx_data;
        if (a <= NST) return mregs[a];
        if (a == 31) return 8'hA1;
        return 8'h00;
    endfunction

    // Reference model: a frame committed by the 16th rise shows at the 4th clock edge.
    always @(posedge clk) begin
        exp_pop  = 1'b0;
        exp_push = 1'b0;
        if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                if (pend_word[14:8] == 0) begin
                    if (pend_word[15]) begin exp_push = 1'b1; exp_txd = pend_word[7:0]; end
                    else exp_pop = 1'b1;
                end else if (pend_word[15] && pend_word[14:8] <= NST) begin
                    mregs[pend_word[14:8]] = pend_word[7:0];
                end
            end
        end
    end

    // Per-clock comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check(regs_o == model_flat(), "R2 register image", regs_o, model_flat());
            check(rx_pop == exp_pop, "R5 rx_pop", 240'(rx_pop), 240'(exp_pop));
            check(tx_push == exp_push, "R6 tx_push", 240'(tx_push), 240'(exp_push));
            if (exp_push) check(tx_data == exp_txd, "R6 tx_data", 240'(tx_data), 240'(exp_txd));
        end
    end

    task automatic xfer(input logic [15:0] w, input int nedges, output logic [7:0] got);
        got  = '0;
        cs_n = 1'b0;
        sclk = 1'b0;
        repeat (HALF) @(negedge clk);
        check(miso_oe == 1'b1, "R8 oe while selected", 240'(miso_oe), 240'(1));
        for (int i = 0; i < nedges; i++) begin
            mosi = (i < 16) ? w[15-i] : 1'b1;
            repeat (HALF) @(negedge clk);
            if (i >= 8 && i < 16) got[15-i] = miso;
            sclk = 1'b1;
            if (i == 15) begin pend_word = w; pend = 4; end
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        mosi = 1'b0;
        repeat (3*HALF) @(negedge clk);
        check(miso_oe == 1'b0, "R8 oe after deselect", 240'(miso_oe), 240'(0));
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] v);
        logic [7:0] g;
        xfer({1'b1, a, v}, 16, g);
    endtask

    task automatic rd(input logic [6:0] a, input string tag);
        logic [7:0] g, e;
        e = mread(a);
        xfer({1'b0, a, 8'h00}, 16, g);
        check(g == e, tag, 240'(g), 240'(e));
    endtask

    initial begin
        logic [7:0] g;
        for (int i = 1; i <= NST; i++) mregs[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R10: reset state
        check(regs_o == '0, "R10 regs after reset", regs_o, '0);
        check(!miso_oe && !rx_pop && !tx_push, "R10 outputs after reset",
              240'({miso_oe, rx_pop, tx_push}), 240'(0));

        // R1 R2 R3: write then read back at both ends of the range
        wr(7'h01, 8'h5A);
        wr(7'h1E, 8'hC3);
        rd(7'h01, "R3 readback 0x01");
        rd(7'h1E, "R3 readback 0x1E");

        // R2: fill all stored registers with a pattern and read each
        for (int a = 1; a <= NST; a++) wr(7'(a), 8'(a * 37 + 11));
        for (int a = 1; a <= NST; a++) rd(7'(a), "R2 pattern readback");

        // R4: revision code, write has no effect
        rd(7'h1F, "R4 revision");
        wr(7'h1F, 8'h00);
        rd(7'h1F, "R4 revision after write");

        // R5: queue pop through address 0
        rx_data = 8'h3C;
        rd(7'h00, "R5 rx byte on MISO");
        rx_data = 8'hE1;
        rd(7'h00, "R5 second rx byte");

        // R6: queue push through address 0
        wr(7'h00, 8'h96);
        wr(7'h00, 8'h01);

        // R7: truncated frames discarded
        xfer({1'b1, 7'h02, 8'hFF}, 12, g);
        rd(7'h02, "R7 truncated write ignored");
        xfer({1'b0, 7'h00, 8'h00}, 15, g);
        xfer({1'b1, 7'h00, 8'h77}, 15, g);

        // R9: unmapped addresses
        wr(7'h40, 8'hAA);
        rd(7'h40, "R9 unmapped read zero");
        wr(7'h7F, 8'h55);
        rd(7'h7F, "R9 top unmapped read zero");
        rd(7'h20, "R9 first unmapped read zero");

        // R11: extra edges beyond the 16th
        xfer({1'b1, 7'h03, 8'h11}, 20, g);
        rd(7'h03, "R11 single commit with first 16 bits");
        xfer({1'b0, 7'h00, 8'h00}, 20, g);

        repeat (20) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule